// File: doc/BRIEF.md
# Phased SPI Transaction Master

This block is an SPI master that runs a single transaction as a chain of up to five phases. The phases always come in the same order: command, address, write, dummy and read. Each phase has its own bit length, and any phase whose length is zero is left out. The controller drives SCLK, MOSI and an active-low chip select, and samples MISO. All data shorter than a full word sits in on-chip registers: a command word, an address word, a 32-bit transmit word and a 32-bit receive word.

A host sets the lengths, the data words, the clock divider and the duplex mode, then pulses `start`. The controller copies the whole configuration at that moment. It holds `busy` until the transaction ends and then raises `done` for one cycle.

In half-duplex mode the write and read phases are separate and each has its own length. In full-duplex mode the write phase also samples MISO. The dummy and read phases are dropped, so the clock count is command plus address plus write bits. The read length then only caps how many of the received bits are stored.

Top module: `spi_phase_master`

## Requirements
- R1: Every transaction emits its phases in the order command, address, write, dummy, read. Command, address and write data leave MSB first: the low `cmd_len` bits of `cmd_word`, then the low `addr_len` bits of `addr_word`, then the low `wr_len` bits of `tx_word`. MOSI is 0 during the dummy and read phases.
- R2: A phase of length zero produces no SCLK cycle. In half duplex the number of SCLK rising edges equals the sum of the five effective lengths. With every length zero, CS still toggles and `done` still pulses, but SCLK never rises.
- R3: Length limits are 16 command bits, 64 address bits and 32 write or read bits. A larger programmed value acts as the limit.
- R4: The dummy phase lasts `dummy_len` SCLK cycles. No received bit from it is stored in `rx_word`.
- R5: In half duplex the read phase stores `rd_len` bits into `rx_word`. They are right-justified, with the first received bit ending up in bit `rd_len-1`, and all higher bits are zero.
- R6: In full duplex the clock count is command plus address plus write length. `rx_word` holds the first min(`rd_len`, `wr_len`) bits sampled during the write phase, right-justified.
- R7: SPI mode 0. SCLK is low whenever CS is high. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge.
- R8: Each SCLK half-period lasts `clk_div`+1 system cycles. CS falls one half-period before the first rising edge and rises one half-period after the last falling edge.
- R9: `busy` is high from the cycle after an accepted start until CS is released. `done` is high for exactly one cycle, in the cycle in which CS returns high and `busy` drops.
- R10: A start while busy is ignored. Configuration inputs that change during a transaction do not affect it.
- R11: After reset, CS is high, SCLK and MOSI are low, and `busy`, `done` and `rx_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| full_duplex | input | 1 | 1: write phase also receives; dummy and read dropped |
| cmd_len | input | 5 | Command bits, 0..16 |
| addr_len | input | 7 | Address bits, 0..64 |
| wr_len | input | 6 | Write bits, 0..32 |
| dummy_len | input | 6 | Dummy SCLK cycles |
| rd_len | input | 6 | Read bits, 0..32 |
| clk_div | input | 8 | SCLK half-period minus one, in system cycles |
| cmd_word | input | 16 | Command value |
| addr_word | input | 64 | Address value |
| tx_word | input | 32 | Write data |
| rx_word | output | 32 | Received data, right-justified |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach is a phase boundary where the next phase is absent. The sequencer must then jump over one or more zero-length phases in a single step, sometimes straight from command to read or to the end. A second hard case is a full-duplex receive limit that stops storing partway through the write phase. The directed stimulus reaches both with length sets in which zero-length phases sit between non-zero ones. It also uses a full-duplex run whose read length is shorter than its write length. A serial slave model in the bench records every MOSI bit and drives a known MISO pattern, so each boundary is visible at the pins. Every length set is compared with the concatenated bit stream expected for it.

// File: rtl/spi_phase_master.sv
module spi_phase_master #(
  parameter int CMD_MAX  = 16,
  parameter int ADDR_MAX = 64,
  parameter int DATA_MAX = 32,
  parameter int DUM_W    = 6,
  parameter int DIV_W    = 8,
  localparam int CLW = $clog2(CMD_MAX + 1),
  localparam int ALW = $clog2(ADDR_MAX + 1),
  localparam int DLW = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                full_duplex,
  input  logic [CLW-1:0]      cmd_len,
  input  logic [ALW-1:0]      addr_len,
  input  logic [DLW-1:0]      wr_len,
  input  logic [DUM_W-1:0]    dummy_len,
  input  logic [DLW-1:0]      rd_len,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic [CMD_MAX-1:0]  cmd_word,
  input  logic [ADDR_MAX-1:0] addr_word,
  input  logic [DATA_MAX-1:0] tx_word,
  output logic [DATA_MAX-1:0] rx_word,
  output logic                busy,
  output logic                done,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic                cs_n
);
  localparam int DUM_MAX = (1 << DUM_W) - 1;
  localparam int M1 = (CMD_MAX > DATA_MAX) ? CMD_MAX : DATA_MAX;
  localparam int M2 = (M1 > ADDR_MAX) ? M1 : ADDR_MAX;
  localparam int MAXL = (M2 > DUM_MAX) ? M2 : DUM_MAX;
  localparam int LW = $clog2(MAXL + 1);
  localparam int NPH = 5;
  localparam logic [2:0] PH_CMD = 3'd0, PH_ADR = 3'd1, PH_WR = 3'd2, PH_RD = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL} st_t;

  st_t st;
  logic [2:0] ph;
  logic act;
  logic [LW-1:0] bcnt, rdlim_q;
  logic [DIV_W-1:0] hcnt, div_q;
  logic fd_q;
  logic [LW-1:0] len_in [NPH];
  logic [LW-1:0] len_q  [NPH];
  logic [NPH-1:0] nz_in, nz_q;
  logic [CMD_MAX-1:0] cmd_q;
  logic [ADDR_MAX-1:0] addr_q;
  logic [DATA_MAX-1:0] tx_q;
  logic tick, last_bit, store, dbit;
  logic [LW-1:0] cur_len, idx;
  logic [3:0] first_pick, next_pick;

  function automatic logic [3:0] pick(input logic [NPH-1:0] nz, input logic [2:0] from);
    logic [3:0] r;
    r = 4'd0;
    for (int i = NPH - 1; i >= 0; i--)
      if (3'(i) >= from && nz[i]) r = {1'b1, 3'(i)};
    return r;
  endfunction

  always_comb begin
    len_in[0] = (cmd_len  > CLW'(CMD_MAX))  ? LW'(CMD_MAX)  : LW'(cmd_len);
    len_in[1] = (addr_len > ALW'(ADDR_MAX)) ? LW'(ADDR_MAX) : LW'(addr_len);
    len_in[2] = (wr_len   > DLW'(DATA_MAX)) ? LW'(DATA_MAX) : LW'(wr_len);
    len_in[3] = full_duplex ? '0 : LW'(dummy_len);
    len_in[4] = full_duplex ? '0 : ((rd_len > DLW'(DATA_MAX)) ? LW'(DATA_MAX) : LW'(rd_len));
  end

  for (genvar g = 0; g < NPH; g++) begin : g_nz
    assign nz_in[g] = len_in[g] != '0;
    assign nz_q[g]  = len_q[g]  != '0;
  end

  assign tick       = hcnt == div_q;
  assign cur_len    = (ph < 3'(NPH)) ? len_q[ph] : '0;
  assign idx        = cur_len - LW'(1) - bcnt;
  assign last_bit   = bcnt == cur_len - LW'(1);
  assign first_pick = pick(nz_in, 3'd0);
  assign next_pick  = pick(nz_q, ph + 3'd1);
  assign store      = (ph == PH_RD) || (fd_q && ph == PH_WR && bcnt < rdlim_q);

  always_comb begin
    case (ph)
      PH_CMD:  dbit = cmd_q[idx[$clog2(CMD_MAX)-1:0]];
      PH_ADR:  dbit = addr_q[idx[$clog2(ADDR_MAX)-1:0]];
      PH_WR:   dbit = tx_q[idx[$clog2(DATA_MAX)-1:0]];
      default: dbit = 1'b0;
    endcase
  end

  assign mosi = act && (st == S_LEAD || st == S_SHIFT) && dbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; act <= 1'b0; bcnt <= '0; hcnt <= '0;
      div_q <= '0; fd_q <= 1'b0; rdlim_q <= '0;
      for (int i = 0; i < NPH; i++) len_q[i] <= '0;
      cmd_q <= '0; addr_q <= '0; tx_q <= '0; rx_word <= '0;
      sclk <= 1'b0; cs_n <= 1'b1; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE) hcnt <= tick ? '0 : hcnt + DIV_W'(1);
      case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < NPH; i++) len_q[i] <= len_in[i];
          rdlim_q <= (rd_len > DLW'(DATA_MAX)) ? LW'(DATA_MAX) : LW'(rd_len);
          fd_q <= full_duplex; div_q <= clk_div;
          cmd_q <= cmd_word; addr_q <= addr_word; tx_q <= tx_word;
          {act, ph} <= first_pick;
          bcnt <= '0; hcnt <= '0; rx_word <= '0;
          cs_n <= 1'b0; busy <= 1'b1; st <= S_LEAD;
        end
        S_LEAD: if (tick) begin
          if (!act) st <= S_TAIL;
          else begin
            st <= S_SHIFT; sclk <= 1'b1;
            if (store) rx_word <= {rx_word[DATA_MAX-2:0], miso};
          end
        end
        S_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (store) rx_word <= {rx_word[DATA_MAX-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (!last_bit) bcnt <= bcnt + LW'(1);
            else begin
              bcnt <= '0;
              {act, ph} <= next_pick;
              if (!next_pick[3]) st <= S_TAIL;
            end
          end
        end
        S_TAIL: if (tick) begin
          cs_n <= 1'b1; busy <= 1'b0; done <= 1'b1; act <= 1'b0; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_phase_master_chk.sv
module spi_phase_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic cs_n
);
  // R7
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R7
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi));
  // R8
  cs_lead_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> !sclk);
  // R9
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) busy == !cs_n);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done && start && !sclk && !$fell(cs_n)) |=> (busy || done));
endmodule

bind spi_phase_master spi_phase_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_phase_master_tb.sv
module spi_phase_master_tb;
  logic clk = 0, rst_n = 0, start = 0, full_duplex = 0;
  logic [4:0] cmd_len = 0;
  logic [6:0] addr_len = 0;
  logic [5:0] wr_len = 0, dummy_len = 0, rd_len = 0;
  logic [7:0] clk_div = 0;
  logic [15:0] cmd_word = 0;
  logic [63:0] addr_word = 0;
  logic [31:0] tx_word = 0;
  logic [31:0] rx_word;
  logic busy, done, sclk, mosi, miso, cs_n;
  int total = 0, bad = 0;

  logic [255:0] pat = 0, cap = 0;
  int nrise = 0;
  realtime t_csf, t_r1, t_r2, t_lastf, t_csr;

  always #2 clk = ~clk;

  spi_phase_master u_dut (.*);

  assign miso = pat[255 - nrise];

  always @(posedge sclk or negedge cs_n) begin
    if (!sclk) begin nrise = 0; cap = 0; t_csf = $realtime; end
    else begin
      cap = {cap[254:0], mosi};
      if (nrise == 0) t_r1 = $realtime;
      if (nrise == 1) t_r2 = $realtime;
      nrise = nrise + 1;
    end
  end
  always @(negedge sclk) t_lastf = $realtime;
  always @(posedge cs_n) t_csr = $realtime;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input bit fd, input int c, input int a, input int w,
                     input int d, input int r, input int div, input logic [15:0] cw,
                     input logic [63:0] aw, input logic [31:0] tw, input logic [255:0] p,
                     input bit poke);
    int ce, ae, we, re, de, n, off, rs, cyc;
    logic [255:0] es;
    logic [31:0] er;
    bit seen;
    ce = c > 16 ? 16 : c; ae = a > 64 ? 64 : a; we = w > 32 ? 32 : w; re = r > 32 ? 32 : r;
    de = fd ? 0 : d;
    es = 0;
    for (int i = 0; i < ce; i++) es = {es[254:0], cw[ce-1-i]};
    for (int i = 0; i < ae; i++) es = {es[254:0], aw[ae-1-i]};
    for (int i = 0; i < we; i++) es = {es[254:0], tw[we-1-i]};
    n = ce + ae + we + (fd ? 0 : de + re);
    for (int i = ce + ae + we; i < n; i++) es = {es[254:0], 1'b0};
    off = fd ? ce + ae : ce + ae + we + de;
    rs = fd ? (re < we ? re : we) : re;
    er = 0;
    for (int i = 0; i < rs; i++) er = {er[30:0], p[255-off-i]};
    @(negedge clk);
    pat = p; full_duplex = fd; cmd_len = 5'(c); addr_len = 7'(a); wr_len = 6'(w);
    dummy_len = 6'(d); rd_len = 6'(r); clk_div = 8'(div);
    cmd_word = cw; addr_word = aw; tx_word = tw; start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1 && cs_n == 0, "R9", {tag, " busy after start"}, {busy, cs_n}, 2'b10);
    seen = 0; cyc = 0;
    while (!seen && cyc < 20000) begin
      if (poke && cyc == 20) begin
        cmd_len = 5'd3; wr_len = 6'd1; cmd_word = 16'h0; tx_word = 32'h0; full_duplex = ~fd; start = 1;
      end
      if (poke && cyc == 21) start = 0;
      @(negedge clk); cyc++;
      if (done) seen = 1;
    end
    chk(seen, "R9", {tag, " done seen"}, seen, 1);
    chk(cs_n == 1 && busy == 0, "R9", {tag, " cs released with done"}, {cs_n, busy}, 2'b10);
    chk(nrise == n, fd ? "R6" : "R2", {tag, " sclk count"}, nrise, n);
    chk(cap == es, "R1", {tag, " mosi stream"}, cap, es);
    chk(rx_word == er, fd ? "R6" : "R5", {tag, " rx word"}, rx_word, er);
    if (n > 0) begin
      chk(t_r1 - t_csf == (div + 1) * 4.0, "R8", {tag, " cs lead"}, int'(t_r1 - t_csf), (div + 1) * 4);
      chk(t_csr - t_lastf == (div + 1) * 4.0, "R8", {tag, " cs tail"}, int'(t_csr - t_lastf), (div + 1) * 4);
    end
    if (n > 1)
      chk(t_r2 - t_r1 == (div + 1) * 8.0, "R8", {tag, " sclk period"}, int'(t_r2 - t_r1), (div + 1) * 8);
    @(negedge clk);
    chk(done == 0, "R9", {tag, " done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && done == 0 && rx_word == 0,
        "R11", "reset state", {cs_n, sclk, mosi, busy, done, rx_word}, {1'b1, 4'b0, 32'h0});
  endtask

  task automatic t_half_all();
    run("R1 R4 half all", 0, 8, 24, 16, 4, 16, 1, 16'h00A5, 64'h00C3_5A7E, 32'h0000_9B1D,
        {64'hF0E1_D2C3_B4A5_9687, 64'h1234_5678_9ABC_DEF0, 128'h0}, 0);
  endtask

  task automatic t_skip_write_only();
    run("R2 write only", 0, 0, 0, 8, 0, 0, 0, 16'hFFFF, 64'hFFFF, 32'h0000_00B6, 256'h0, 0);
  endtask

  task automatic t_cmd_to_read();
    run("R2 R4 cmd dummy read", 0, 8, 0, 0, 8, 32, 2, 16'h003B, 64'h0, 32'hFFFF_FFFF,
        {32'hFFFF_FFFF, 32'hDEAD_BEEF, 192'h0}, 0);
  endtask

  task automatic t_full_duplex();
    run("R6 full duplex", 1, 8, 8, 32, 5, 12, 1, 16'h009C, 64'h0071, 32'h8421_F00F,
        {64'h3C3C_A5A5_0FF0_6699, 192'h0}, 0);
  endtask

  task automatic t_limits();
    run("R3 limits", 0, 20, 100, 40, 0, 0, 0, 16'hC001, 64'h8000_0000_0000_0001, 32'h8000_0001,
        256'h0, 0);
  endtask

  task automatic t_busy_start();
    run("R10 start busy", 0, 4, 0, 16, 2, 8, 3, 16'h000A, 64'h0, 32'h0000_C35A,
        {32'h0, 32'h00F5_0000, 192'h0}, 1);
  endtask

  task automatic t_empty();
    run("R2 empty", 0, 0, 0, 0, 0, 0, 1, 16'hFFFF, 64'h0, 32'hFFFF_FFFF, 256'h0, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_half_all();
    t_skip_write_only();
    t_cmd_to_read();
    t_full_duplex();
    t_limits();
    t_busy_start();
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule